// File: doc/BRIEF.md
# JTAG Debug Command Receiver

This block is the data-register side of a debug unit reached through a JTAG port. A TAP controller, outside the block, decodes the state machine and hands over three per-bit strobes (capture, shift, update) together with the serial input bit. The block uses them to take in a serial frame from the debug host, check the frame's CRC, and shift back a short status word followed by a CRC of that word. On the TAP's update strobe it commits what an accepted frame asked for. A frame either selects one of eight scan chains or carries a command with an address and, for some commands, a transfer length.

The serial path is paced entirely by the shift strobe. There is no valid/ready pair and no back-pressure. Every cycle with shift high consumes one input bit and presents the next output bit, and the block never stalls the TAP. Bus progress and bus failure arrive as plain level inputs. They are sampled in the cycle that carries the host's last CRC bit. The committed chain and command are plain outputs, and a single-cycle go pulse marks each newly committed command.

A frame begins with a 4-bit command field. If the host's CRC does not match, the block reports a failure and changes nothing. The same holds for a select to a chain the validity table rejects, and for a command issued while no valid chain is selected.

Top module: `dbg_cmd_receiver`

## Requirements
- R1: Each frame opens with a 4-bit command field, shifted MSB first. When its top bit is 1, the frame is a chain select: the low 3 bits name the chain, and the 32 CRC bits follow directly.
- R2: When the top bit of the command field is 0, the low 3 bits are a command code. Codes 0 to 3 are followed by a 32-bit address and then a 16-bit length. Codes 4 to 6 are followed by the 32-bit address only. Code 7 is a status query with no payload. All fields are sent MSB first and are followed by the host's 32-bit CRC, also MSB first.
- R3: The CRC register clears on capture and is updated once per header bit. It shifts left by one, and the result is XORed with 0x04C11DB7 when the incoming bit differs from the old bit 31. The host's CRC must equal the register value after the last header bit.
- R4: On the shift cycle right after the host's last CRC bit, tdo presents the 4-bit status, MSB first. The 32-bit CRC of those four status bits follows, MSB first. At all other times, including after capture and past the end of the reply, tdo is 0.
- R5: A select with a good CRC returns 1101 if the chain is valid and 1111 if it is not. With the default table, chains 1, 3, 4, 5 and 6 are valid and chains 0, 2 and 7 are not.
- R6: After reset, no chain is selected (chain_ok 0, chain_id 0). An accepted select to a valid chain changes chain_id and chain_ok only on the following update strobe, and they are visible in the cycle after that strobe.
- R7: A CRC mismatch returns status 0000. The following update then leaves the selected chain and the latched command unchanged and raises no go pulse.
- R8: A command frame with a good CRC while no valid chain is selected returns 1110 and is not latched.
- R9: A command frame with a good CRC and a valid chain returns one of three codes. It returns 1100 if it is a status query and bus_busy is high. Otherwise it returns 1001 if bus_err is high, and 1000 in all other cases. The bus inputs are sampled in the cycle of the host's last CRC bit.
- R10: The update after a non-query command that returned 1000 latches the code, the address and the length into cmd_code, cmd_addr and cmd_len, and pulses cmd_go for exactly one cycle. The length reads 0 for an address-only command. A status query never latches and never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| capture | input | 1 | TAP capture strobe; restarts the frame |
| shift | input | 1 | TAP shift strobe; one bit per cycle |
| update | input | 1 | TAP update strobe; commits an accepted frame |
| tdi | input | 1 | Serial input bit |
| tdo | output | 1 | Serial output bit |
| bus_busy | input | 1 | Bus cycle still in progress |
| bus_err | input | 1 | Bus cycle ended in error |
| chain_id | output | 3 | Selected chain number |
| chain_ok | output | 1 | A valid chain is selected |
| cmd_code | output | 3 | Latched command code |
| cmd_addr | output | 32 | Latched command address |
| cmd_len | output | 16 | Latched command length |
| cmd_go | output | 1 | One-cycle pulse on each command commit |

## Verification
The assertions watch several rules on every clock:
- The chain outputs move only on an update strobe.
- The go pulse only follows an update strobe.
- A committed chain is always one the table accepts.
- A CRC mismatch leaves nothing pending.
- The end-of-frame strobe is a single cycle.
- Header fields freeze once the header is over.
- tdo is quiet after capture and carries the status MSB right after the last input bit.

Only the bench's scenarios can show the rest. This covers the actual status code and its CRC for each frame kind, with and without a corrupted CRC or the bus inputs raised. It also covers the exact length of each frame type and the values latched for address-only and full commands.

// File: rtl/dbg_rx_pkg.sv
package dbg_rx_pkg;
  localparam int CMD_W   = 4;
  localparam int CHAIN_W = CMD_W - 1;
  localparam int STAT_W  = 4;
  localparam int CRC_W   = 32;
  localparam logic [CHAIN_W-1:0] CODE_QUERY = '1;

  typedef enum logic [STAT_W-1:0] {
    ST_CRC_ERR  = 4'b0000,
    ST_CMD_OK   = 4'b1000,
    ST_BUS_ERR  = 4'b1001,
    ST_BUSY     = 4'b1100,
    ST_SEL_OK   = 4'b1101,
    ST_NO_CHAIN = 4'b1110,
    ST_SEL_BAD  = 4'b1111
  } status_e;

  // One serial CRC step: shift left, fold in the polynomial on a mismatch.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] crc,
                                                input logic din,
                                                input logic [CRC_W-1:0] poly);
    return {crc[CRC_W-2:0], 1'b0} ^ ((din ^ crc[CRC_W-1]) ? poly : '0);
  endfunction
endpackage

// File: rtl/dbg_crc_serial.sv
module dbg_crc_serial
  import dbg_rx_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= crc_step(crc, din, POLY);
  end
endmodule

// File: rtl/dbg_frame_rx.sv
module dbg_frame_rx
  import dbg_rx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              shift,
  input  logic              tdi,
  output logic              frame_done,
  output logic              crc_ok,
  output logic [CMD_W-1:0]  cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  len
);
  localparam int HDR_MAX = CMD_W + ADDR_W + LEN_W;
  localparam int CNT_W   = $clog2(HDR_MAX + CRC_W + 1);
  localparam logic [CNT_W-1:0] N_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] N_CMD   = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] N_ADR   = CNT_W'(CMD_W + ADDR_W);
  localparam logic [CNT_W-1:0] N_HDR   = CNT_W'(HDR_MAX);
  localparam logic [CNT_W-1:0] N_CRC   = CNT_W'(CRC_W);
  localparam logic [CNT_W-1:0] N_CRCM1 = CNT_W'(CRC_W - 1);

  logic [CNT_W-1:0] cnt, hdr_len;
  logic [CRC_W-1:0] rx_crc, run_crc;
  logic step, in_cmd, in_hdr, in_crc, last_bit;

  assign step = shift && !capture;

  // Header length follows from the command field (R1, R2).
  always_comb begin
    if (cmd[CMD_W-1] || cmd[CHAIN_W-1:0] == CODE_QUERY) hdr_len = N_CMD;
    else if (cmd[CHAIN_W-1])                            hdr_len = N_ADR;
    else                                                hdr_len = N_HDR;
  end

  assign in_cmd   = cnt < N_CMD;
  assign in_hdr   = in_cmd || (cnt < hdr_len);
  assign in_crc   = !in_hdr && (cnt < hdr_len + N_CRC);
  assign last_bit = in_crc && (cnt == hdr_len + N_CRCM1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; cmd <= '0; addr <= '0; len <= '0; rx_crc <= '0;
    end else if (capture) begin
      cnt <= '0; cmd <= '0; addr <= '0; len <= '0; rx_crc <= '0;
    end else if (shift) begin
      if (cnt != '1) cnt <= cnt + N_ONE;
      if (in_cmd)                     cmd    <= {cmd[CMD_W-2:0], tdi};
      else if (in_hdr && cnt < N_ADR) addr   <= {addr[ADDR_W-2:0], tdi};
      else if (in_hdr)                len    <= {len[LEN_W-2:0], tdi};
      else if (in_crc)                rx_crc <= {rx_crc[CRC_W-2:0], tdi};
    end
  end

  dbg_crc_serial #(.POLY(POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(capture), .en(step && in_hdr),
    .din(tdi), .crc(run_crc)
  );

  // R3: the host CRC, completed by the current bit, against the header CRC.
  assign frame_done = step && last_bit;
  assign crc_ok     = ({rx_crc[CRC_W-2:0], tdi} == run_crc);

  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  a_r3_crc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (run_crc == '0));
  a_r2_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !capture && !in_hdr) |=> ($stable(cmd) && $stable(addr) && $stable(len)));
endmodule

// File: rtl/dbg_status_tx.sv
module dbg_status_tx
  import dbg_rx_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              shift,
  input  logic              load,
  input  logic [STAT_W-1:0] status,
  output logic              tdo
);
  localparam int OUT_W = STAT_W + CRC_W;

  logic [OUT_W-1:0] sr;
  logic [CRC_W-1:0] st_crc;

  // CRC over the status bits in the order they leave (R4).
  always_comb begin
    st_crc = '0;
    for (int i = STAT_W - 1; i >= 0; i--) st_crc = crc_step(st_crc, status[i], POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr <= '0;
    else if (capture) sr <= '0;
    else if (load)    sr <= {status, st_crc};
    else if (shift)   sr <= {sr[OUT_W-2:0], 1'b0};
  end

  assign tdo = sr[OUT_W-1];

  a_r4_quiet_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !tdo);
  a_r4_status_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !capture) |=> (tdo == $past(status[STAT_W-1])));
endmodule

// File: rtl/dbg_cmd_receiver.sv
module dbg_cmd_receiver
  import dbg_rx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7,
  parameter logic [(1<<CHAIN_W)-1:0] VALID_CHAINS = 8'b0111_1010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic               shift,
  input  logic               update,
  input  logic               tdi,
  output logic               tdo,
  input  logic               bus_busy,
  input  logic               bus_err,
  output logic [CHAIN_W-1:0] chain_id,
  output logic               chain_ok,
  output logic [CHAIN_W-1:0] cmd_code,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [LEN_W-1:0]   cmd_len,
  output logic               cmd_go
);
  logic              frame_done, crc_ok;
  logic [CMD_W-1:0]  rx_cmd;
  logic [ADDR_W-1:0] rx_addr;
  logic [LEN_W-1:0]  rx_len;
  status_e           status;
  logic              pend_sel, pend_cmd;
  logic              is_sel, is_query;

  dbg_frame_rx #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .POLY(POLY)) u_rx (
    .clk(clk), .rst_n(rst_n), .capture(capture), .shift(shift), .tdi(tdi),
    .frame_done(frame_done), .crc_ok(crc_ok), .cmd(rx_cmd), .addr(rx_addr), .len(rx_len)
  );

  assign is_sel   = rx_cmd[CMD_W-1];
  assign is_query = (rx_cmd[CHAIN_W-1:0] == CODE_QUERY);

  // Status selection (R5, R7, R8, R9).
  always_comb begin
    if (!crc_ok)                   status = ST_CRC_ERR;
    else if (is_sel)               status = VALID_CHAINS[rx_cmd[CHAIN_W-1:0]] ? ST_SEL_OK : ST_SEL_BAD;
    else if (!chain_ok)            status = ST_NO_CHAIN;
    else if (is_query && bus_busy) status = ST_BUSY;
    else if (bus_err)              status = ST_BUS_ERR;
    else                           status = ST_CMD_OK;
  end

  dbg_status_tx #(.POLY(POLY)) u_tx (
    .clk(clk), .rst_n(rst_n), .capture(capture), .shift(shift),
    .load(frame_done), .status(status), .tdo(tdo)
  );

  // Accepted frames wait for the update strobe (R6, R10).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_sel <= 1'b0; pend_cmd <= 1'b0;
      chain_id <= '0; chain_ok <= 1'b0;
      cmd_code <= '0; cmd_addr <= '0; cmd_len <= '0; cmd_go <= 1'b0;
    end else begin
      cmd_go <= 1'b0;
      if (capture) begin
        pend_sel <= 1'b0;
        pend_cmd <= 1'b0;
      end else if (frame_done) begin
        pend_sel <= (status == ST_SEL_OK);
        pend_cmd <= (status == ST_CMD_OK) && !is_query;
      end else if (update) begin
        if (pend_sel) begin
          chain_id <= rx_cmd[CHAIN_W-1:0];
          chain_ok <= 1'b1;
        end
        if (pend_cmd) begin
          cmd_code <= rx_cmd[CHAIN_W-1:0];
          cmd_addr <= rx_addr;
          cmd_len  <= rx_len;
          cmd_go   <= 1'b1;
        end
        pend_sel <= 1'b0;
        pend_cmd <= 1'b0;
      end
    end
  end

  a_r6_chain_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> ($stable(chain_id) && $stable(chain_ok)));
  a_r5_chain_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    chain_ok |-> VALID_CHAINS[chain_id]);
  a_r7_crc_err_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !crc_ok) |=> (!pend_sel && !pend_cmd));
  a_r10_go_after_update: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> $past(update));
endmodule

// File: tb/tb_dbg_cmd_receiver.sv
`timescale 1ns/1ps
module tb_dbg_cmd_receiver;
  localparam logic [31:0] POLY = 32'h04C11DB7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
  logic bus_busy = 1'b0, bus_err = 1'b0;
  logic tdo, chain_ok, cmd_go;
  logic [2:0] chain_id, cmd_code;
  logic [31:0] cmd_addr;
  logic [15:0] cmd_len;

  int checks = 0, errors = 0;
  bit model_on = 1'b0;

  always #2.5 clk = ~clk;

  dbg_cmd_receiver dut (
    .clk(clk), .rst_n(rst_n), .capture(capture), .shift(shift), .update(update),
    .tdi(tdi), .tdo(tdo), .bus_busy(bus_busy), .bus_err(bus_err),
    .chain_id(chain_id), .chain_ok(chain_ok), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_go(cmd_go)
  );

  function automatic logic [31:0] crc_upd(logic [31:0] c, bit b);
    return {c[30:0], 1'b0} ^ ((b ^ c[31]) ? POLY : 32'h0);
  endfunction

  function automatic logic [31:0] crc4(logic [3:0] s);
    logic [31:0] c = 32'h0;
    for (int i = 3; i >= 0; i--) c = crc_upd(c, s[i]);
    return c;
  endfunction

  function automatic int hdr_bits(logic [3:0] c);
    if (c[3] || c[2:0] == 3'd7) return 4;
    return c[2] ? 36 : 52;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  bit m_rx[$];
  bit m_tx[$];
  logic [2:0] m_chain = 0, m_code = 0, m_pch = 0, m_pcode = 0;
  logic [31:0] m_addr = 0, m_paddr = 0;
  logic [15:0] m_len = 0, m_plen = 0;
  bit m_ok = 0, m_go = 0, m_psel = 0, m_pcmd = 0;

  always @(posedge clk) begin
    logic [3:0] c, st;
    logic [31:0] cc, rc, a, sc;
    logic [15:0] l;
    int h;
    if (!rst_n) begin
      m_rx.delete(); m_tx.delete();
      m_chain = 0; m_ok = 0; m_code = 0; m_addr = 0; m_len = 0; m_go = 0;
      m_psel = 0; m_pcmd = 0;
    end else begin
      m_go = 0;
      if (update) begin
        if (m_psel) begin m_chain = m_pch; m_ok = 1; end
        if (m_pcmd) begin m_code = m_pcode; m_addr = m_paddr; m_len = m_plen; m_go = 1; end
        m_psel = 0; m_pcmd = 0;
      end
      if (capture) begin
        m_rx.delete(); m_tx.delete(); m_psel = 0; m_pcmd = 0;
      end else if (shift) begin
        if (m_tx.size() > 0) void'(m_tx.pop_front());
        m_rx.push_back(tdi);
        if (m_rx.size() >= 4) begin
          c = {m_rx[0], m_rx[1], m_rx[2], m_rx[3]};
          h = hdr_bits(c);
          if (m_rx.size() == h + 32) begin
            cc = 0; for (int i = 0; i < h; i++) cc = crc_upd(cc, m_rx[i]);
            rc = 0; for (int i = 0; i < 32; i++) rc = {rc[30:0], m_rx[h + i]};
            a = 0; if (h > 4) for (int i = 4; i < 36; i++) a = {a[30:0], m_rx[i]};
            l = 0; if (h == 52) for (int i = 36; i < 52; i++) l = {l[14:0], m_rx[i]};
            if (rc != cc) st = 4'b0000;
            else if (c[3]) st = (c[2:0] inside {3'd1, 3'd3, 3'd4, 3'd5, 3'd6}) ? 4'b1101 : 4'b1111;
            else if (!m_ok) st = 4'b1110;
            else if (c[2:0] == 3'd7 && bus_busy) st = 4'b1100;
            else if (bus_err) st = 4'b1001;
            else st = 4'b1000;
            m_tx.delete();
            for (int i = 3; i >= 0; i--) m_tx.push_back(st[i]);
            sc = crc4(st);
            for (int i = 31; i >= 0; i--) m_tx.push_back(sc[i]);
            m_psel = (st == 4'b1101);
            m_pcmd = (st == 4'b1000) && (c[2:0] != 3'd7);
            m_pch = c[2:0]; m_pcode = c[2:0]; m_paddr = a; m_plen = l;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk("R4", "tdo vs model", tdo, (m_tx.size() > 0) ? m_tx[0] : 1'b0);
      chk("R6", "chain_id vs model", chain_id, m_chain);
      chk("R6", "chain_ok vs model", chain_ok, m_ok);
      chk("R10", "cmd_go vs model", cmd_go, m_go);
      chk("R10", "cmd_code vs model", cmd_code, m_code);
      chk("R10", "cmd_addr vs model", cmd_addr, m_addr);
      chk("R10", "cmd_len vs model", cmd_len, m_len);
    end
  end

  task automatic frame(input logic [3:0] c, input logic [31:0] a, input logic [15:0] l,
                       input bit bad, output logic [3:0] st, output logic [31:0] sc);
    bit q[$];
    logic [31:0] cr;
    int h = hdr_bits(c);
    for (int i = 3; i >= 0; i--) q.push_back(c[i]);
    if (h > 4) for (int i = 31; i >= 0; i--) q.push_back(a[i]);
    if (h == 52) for (int i = 15; i >= 0; i--) q.push_back(l[i]);
    cr = 0;
    foreach (q[i]) cr = crc_upd(cr, q[i]);
    if (bad) cr[7] = ~cr[7];
    for (int i = 31; i >= 0; i--) q.push_back(cr[i]);
    @(negedge clk); capture = 1; shift = 0; update = 0;
    foreach (q[i]) begin @(negedge clk); capture = 0; shift = 1; tdi = q[i]; end
    st = 0; sc = 0;
    for (int i = 0; i < 36; i++) begin
      @(negedge clk); shift = 1; tdi = 0;
      if (i < 4) st = {st[2:0], tdo}; else sc = {sc[30:0], tdo};
    end
    @(negedge clk); shift = 0;
  endtask

  task automatic run(string tag, logic [3:0] c, logic [31:0] a, logic [15:0] l,
                     bit bad, logic [3:0] exp_st);
    logic [3:0] st;
    logic [31:0] sc;
    frame(c, a, l, bad, st, sc);
    chk(tag, "status", st, exp_st);
    chk("R3", "status crc", sc, crc4(exp_st));
  endtask

  task automatic do_update();
    @(negedge clk); update = 1;
    @(negedge clk); update = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; model_on = 1;
    @(negedge clk);
    chk("R6", "reset chain_ok", chain_ok, 0);
    chk("R6", "reset chain_id", chain_id, 0);
    chk("R4", "reset tdo", tdo, 0);
    chk("R10", "reset cmd_go", cmd_go, 0);

    // R8: command before any chain is selected
    run("R8", 4'b0001, 32'h1111_2222, 16'h0003, 0, 4'b1110);
    do_update();
    chk("R8", "no go without chain", cmd_go, 0);
    chk("R8", "addr untouched", cmd_addr, 0);

    // R1 R5 R6: select chain 3
    run("R5", 4'b1011, 0, 0, 0, 4'b1101);
    @(negedge clk); update = 1;
    chk("R6", "chain_ok before update", chain_ok, 0);
    @(negedge clk); update = 0;
    chk("R6", "chain_id after update", chain_id, 3);
    chk("R1", "chain_ok after update", chain_ok, 1);

    // R5: invalid chains 2, 0, 7
    run("R5", 4'b1010, 0, 0, 0, 4'b1111); do_update();
    chk("R5", "chain kept after invalid 2", chain_id, 3);
    run("R5", 4'b1000, 0, 0, 0, 4'b1111); do_update();
    run("R5", 4'b1111, 0, 0, 0, 4'b1111); do_update();
    chk("R5", "chain kept after invalid 7", chain_id, 3);

    // R7: select with corrupted CRC
    run("R7", 4'b1101, 0, 0, 1, 4'b0000); do_update();
    chk("R7", "chain kept after bad crc", chain_id, 3);

    // R2 R9 R10: full command
    run("R9", 4'b0001, 32'hDEAD_BEEF, 16'h1234, 0, 4'b1000);
    do_update();
    chk("R10", "go pulse", cmd_go, 1);
    chk("R2", "code", cmd_code, 1);
    chk("R2", "addr", cmd_addr, 32'hDEAD_BEEF);
    chk("R2", "len", cmd_len, 16'h1234);
    @(negedge clk);
    chk("R10", "go single cycle", cmd_go, 0);

    // R2 R10: address-only command
    run("R2", 4'b0101, 32'h00C0_FFEE, 16'hFFFF, 0, 4'b1000);
    do_update();
    chk("R10", "addr-only code", cmd_code, 5);
    chk("R10", "addr-only addr", cmd_addr, 32'h00C0_FFEE);
    chk("R10", "addr-only len zero", cmd_len, 0);

    // R7: command with corrupted CRC
    run("R7", 4'b0010, 32'h5555_AAAA, 16'h0042, 1, 4'b0000);
    do_update();
    chk("R7", "no go after bad crc", cmd_go, 0);
    chk("R7", "addr kept after bad crc", cmd_addr, 32'h00C0_FFEE);

    // R9: bus error
    bus_err = 1;
    run("R9", 4'b0000, 32'h0000_0100, 16'h0004, 0, 4'b1001);
    bus_err = 0;
    do_update();
    chk("R9", "no go on bus error", cmd_go, 0);

    // R9 R10: status query busy and idle
    bus_busy = 1;
    run("R9", 4'b0111, 0, 0, 0, 4'b1100);
    bus_busy = 0;
    do_update();
    run("R9", 4'b0111, 0, 0, 0, 4'b1000);
    do_update();
    chk("R10", "query never latches", cmd_go, 0);
    chk("R10", "code kept after query", cmd_code, 5);

    // R6: move to chain 4, then a command still works
    run("R6", 4'b1100, 0, 0, 0, 4'b1101); do_update();
    chk("R6", "chain 4 selected", chain_id, 4);
    run("R9", 4'b0110, 32'h8000_0001, 0, 0, 4'b1000); do_update();
    chk("R10", "code 6 latched", cmd_code, 6);

    // R4: tdo quiet past the end of the reply
    repeat (3) begin @(negedge clk); shift = 1; tdi = 1; chk("R4", "tdo after reply", tdo, 0); end
    @(negedge clk); shift = 0; tdi = 0;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule